// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is one bank of 32 general-purpose pins behind a small memory-mapped register bus. For each pin it drives an output value and an output enable. It brings the pad level in through a synchroniser. It can also raise an interrupt from a pin. Each pin picks its trigger: rising edge, falling edge, high level or low level. Detected events latch into sticky status bits. A per-pin enable masks these bits, and the OR of the unmasked bits forms a single interrupt line.

Every register has three write addresses. A plain write replaces the value. A set alias ORs the written mask in. A clear alias removes the bits where the mask is one. This lets software change one pin without a read-modify-write sequence. Software acknowledges an interrupt by writing that pin's bit to the clear alias of the status register.

Register map: each register occupies a 16-byte slot at index×0x10, with the plain write at +0x0, the set alias at +0x4 and the clear alias at +0x8. The indices are:

| Index | Register |
|---|---|
| 0 | output data |
| 1 | output enable |
| 2 | input level (read-only) |
| 3 | interrupt participation |
| 4 | interrupt enable |
| 5 | level select |
| 6 | polarity select |
| 7 | status |

Top module: `gpio_bank`

## Requirements
- R1: A write to offset +0x0 of a register slot replaces the register with the written data; a read at +0x0 returns the register.
- R2: A write to offset +0x4 ORs the written mask into the register, leaving other bits unchanged.
- R3: A write to offset +0x8 clears exactly the bits where the written mask is 1.
- R4: After reset every register reads 0, pinOut and pinOe are 0 and irqOut is low.
- R5: pinOut and pinOe follow registers 0 and 1 bit for bit. Register 2 reads the pad level after a two-flop synchroniser, so a pad change is visible two clock edges later. Writes to register 2 are ignored.
- R6: With the level bit 0 and the polarity bit 1, a pin's status bit sets on a rising synchronised edge. With both bits 0, it sets on a falling edge. A status bit latches until software clears it.
- R7: With the level bit 1, the status bit sets while the synchronised pin equals the polarity bit (1 means high level, 0 means low level). The bit is set again on every cycle the level persists, so a clear takes effect only after the level is gone.
- R8: A pin whose bit in register 3 is 0 never sets its status bit, whatever its type and level.
- R9: irqOut is high exactly when some bit of status AND interrupt-enable is 1. Clearing register 4 drops irqOut while the status bits are retained.
- R10: If a detected event and a software clear reach the same status bit on the same clock edge, the bit ends up set.
- R11: Reads at any offset that is not +0x0 of slots 0 to 7 return 0, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte address of the register access |
| busWrEn | input | 1 | Write strobe, one write per cycle |
| busWrData | input | 32 | Write data or mask |
| busRdData | output | 32 | Combinational read data for busAddr |
| pinIn | input | 32 | Pad input levels (asynchronous) |
| pinOut | output | 32 | Output data to pads |
| pinOe | output | 32 | Output enable to pads |
| irqOut | output | 1 | Summary interrupt to the processor |

## Verification
The case that needs care is a hardware event and a software clear reaching the same status bit on the same clock edge. To provoke it, the bench first sets the bit by software. It then moves a rising-edge pin and times a clear-alias write to land on the edge at which the synchronised edge is detected. The bit must read back as 1, while an identical clear one cycle later, with no event pending, must read 0. A level-high pin held active during a clear exercises the same path, since the detector asserts on every cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int REG_CNT = 8;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } busOpE;

  typedef enum logic [2:0] {
    REG_DOUT = 3'd0,
    REG_OE   = 3'd1,
    REG_IN   = 3'd2,
    REG_SEL  = 3'd3,
    REG_EN   = 3'd4,
    REG_LVL  = 3'd5,
    REG_POL  = 3'd6,
    REG_STAT = 3'd7
  } regIdE;

  typedef struct packed {
    busOpE op;
    regIdE wrReg;
    logic  rdHit;
    regIdE rdReg;
  } ctrlStrobeT;

endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobeT        strobes
);

  localparam int IDX_LO = 4;
  localparam int IDX_HI = IDX_LO + $clog2(REG_CNT) - 1;

  logic       slotValid;
  logic [3:0] subOff;
  regIdE      slotId;

  assign subOff = busAddr[IDX_LO-1:0];
  assign slotId = regIdE'(busAddr[IDX_HI:IDX_LO]);

  generate
    if (ADDR_W > IDX_HI + 1) begin : gUpper
      assign slotValid = (busAddr[ADDR_W-1:IDX_HI+1] == '0);
    end else begin : gNoUpper
      assign slotValid = 1'b1;
    end
  endgenerate

  always_comb begin
    strobes.op    = OP_NONE;
    strobes.wrReg = slotId;
    strobes.rdReg = slotId;
    strobes.rdHit = slotValid && (subOff == 4'h0);
    if (busWrEn && slotValid && (slotId != REG_IN)) begin
      unique case (subOff)
        4'h0:    strobes.op = OP_WRITE;
        4'h4:    strobes.op = OP_SET;
        4'h8:    strobes.op = OP_CLEAR;
        default: strobes.op = OP_NONE;
      endcase
    end
  end

endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strobes,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  output logic             irqOut
);

  logic [WIDTH-1:0] doutQ, oeQ, selQ, enQ, lvlQ, polQ, statQ;
  logic [WIDTH-1:0] syncQ [SYNC_STAGES];
  logic [WIDTH-1:0] prevQ, pinSync;
  logic [WIDTH-1:0] riseVec, fallVec, levelHit, edgeHit, hitVec, statNext;

  function automatic logic [WIDTH-1:0] applyOp(input logic [WIDTH-1:0] oldVal,
                                               input logic [WIDTH-1:0] mask,
                                               input busOpE op);
    unique case (op)
      OP_WRITE: return mask;
      OP_SET:   return oldVal | mask;
      OP_CLEAR: return oldVal & ~mask;
      default:  return oldVal;
    endcase
  endfunction

  function automatic logic hitsReg(input ctrlStrobeT s, input regIdE id);
    return (s.op != OP_NONE) && (s.wrReg == id);
  endfunction

  // Input synchroniser chain
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= pinIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign pinSync = syncQ[SYNC_STAGES-1];

  // Control registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doutQ <= '0;
      oeQ   <= '0;
      selQ  <= '0;
      enQ   <= '0;
      lvlQ  <= '0;
      polQ  <= '0;
    end else begin
      if (hitsReg(strobes, REG_DOUT)) doutQ <= applyOp(doutQ, wrData, strobes.op);
      if (hitsReg(strobes, REG_OE))   oeQ   <= applyOp(oeQ, wrData, strobes.op);
      if (hitsReg(strobes, REG_SEL))  selQ  <= applyOp(selQ, wrData, strobes.op);
      if (hitsReg(strobes, REG_EN))   enQ   <= applyOp(enQ, wrData, strobes.op);
      if (hitsReg(strobes, REG_LVL))  lvlQ  <= applyOp(lvlQ, wrData, strobes.op);
      if (hitsReg(strobes, REG_POL))  polQ  <= applyOp(polQ, wrData, strobes.op);
    end
  end

  // Event detection: level pins match polarity, edge pins follow polarity direction
  assign riseVec  = pinSync & ~prevQ;
  assign fallVec  = ~pinSync & prevQ;
  assign levelHit = lvlQ & ~(polQ ^ pinSync);
  assign edgeHit  = ~lvlQ & ((polQ & riseVec) | (~polQ & fallVec));
  assign hitVec   = selQ & (levelHit | edgeHit);

  // Hardware set is ORed after the software op, so it wins a collision
  always_comb begin
    statNext = statQ;
    if (hitsReg(strobes, REG_STAT)) statNext = applyOp(statQ, wrData, strobes.op);
    statNext = statNext | hitVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) statQ <= '0;
    else       statQ <= statNext;
  end

  assign irqOut = |(statQ & enQ);
  assign pinOut = doutQ;
  assign pinOe  = oeQ;

  always_comb begin
    rdData = '0;
    if (strobes.rdHit) begin
      unique case (strobes.rdReg)
        REG_DOUT: rdData = doutQ;
        REG_OE:   rdData = oeQ;
        REG_IN:   rdData = pinSync;
        REG_SEL:  rdData = selQ;
        REG_EN:   rdData = enQ;
        REG_LVL:  rdData = lvlQ;
        REG_POL:  rdData = polQ;
        REG_STAT: rdData = statQ;
        default:  rdData = '0;
      endcase
    end
  end

  // Assertions
  assert_reset_quiet_R4: assert property (@(posedge clk)
    !rstN |=> (pinOe == '0 && pinOut == '0 && !irqOut && statQ == '0));

  assert_set_keeps_bits_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.op == OP_SET && strobes.wrReg == REG_DOUT)
      |=> ((doutQ & $past(doutQ)) == $past(doutQ)));

  assert_hw_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (hitVec != '0) |=> ((statQ & $past(hitVec)) == $past(hitVec)));

  assert_unselected_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !hitsReg(strobes, REG_STAT)
      |=> ((statQ & ~$past(statQ) & ~$past(selQ)) == '0));

  assert_mask_all_R9: assert property (@(posedge clk) disable iff (!rstN)
    (enQ == '0) |-> !irqOut);

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [WIDTH-1:0]  busWrData,
  output logic [WIDTH-1:0]  busRdData,
  input  logic [WIDTH-1:0]  pinIn,
  output logic [WIDTH-1:0]  pinOut,
  output logic [WIDTH-1:0]  pinOe,
  output logic              irqOut
);

  ctrlStrobeT strobes;

  gpio_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .strobes (strobes)
  );

  gpio_datapath #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (busWrData),
    .pinIn   (pinIn),
    .rdData  (busRdData),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .irqOut  (irqOut)
  );

endmodule

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
module tb_gpio_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] pinIn = 32'h0000_0006;
  logic [31:0] pinOut, pinOe;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  gpio_bank dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  // {isWrite, addr, data, expectedRead}
  localparam int NVEC = 14;
  localparam logic [72:0] VECS [NVEC] = '{
    {1'b1, 8'h00, 32'hA5A5_0000, 32'h0},
    {1'b0, 8'h00, 32'h0,         32'hA5A5_0000},  // R1
    {1'b1, 8'h04, 32'h0000_00FF, 32'h0},
    {1'b0, 8'h00, 32'h0,         32'hA5A5_00FF},  // R2
    {1'b1, 8'h08, 32'hA000_000F, 32'h0},
    {1'b0, 8'h00, 32'h0,         32'h05A5_00F0},  // R3
    {1'b1, 8'h10, 32'hFFFF_0000, 32'h0},
    {1'b1, 8'h18, 32'h0F00_0000, 32'h0},
    {1'b0, 8'h10, 32'h0,         32'hF0FF_0000},  // R3
    {1'b1, 8'h20, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h20, 32'h0,         32'h0000_0006},  // R5 write ignored
    {1'b1, 8'h90, 32'h0000_1234, 32'h0},
    {1'b0, 8'h90, 32'h0,         32'h0},          // R11
    {1'b0, 8'h0C, 32'h0,         32'h0}           // R11
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [7:0] a, input logic [31:0] exp);
    busAddr = a;
    #1;
    check(req, busRdData, exp);
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    waitCycles(3);
    // R4: reset state
    for (int r = 0; r < 8; r++) readCheck("R4", 8'(r * 16), 32'h0);
    check("R4 pinOe", pinOe, 32'h0);
    check("R4 irqOut", {31'h0, irqOut}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    waitCycles(2);

    for (int v = 0; v < NVEC; v++) begin
      if (VECS[v][72]) busWrite(VECS[v][71:64], VECS[v][63:32]);
      else readCheck("R1/R2/R3/R5/R11 vector", VECS[v][71:64], VECS[v][31:0]);
    end
    check("R5 pinOut", pinOut, 32'h05A5_00F0);
    check("R5 pinOe", pinOe, 32'hF0FF_0000);
    busWrite(8'h00, 32'h0);
    busWrite(8'h10, 32'h0);

    // Types: pin0 rising, pin1 falling, pin2 low level, pin3 high level
    busWrite(8'h50, 32'h0000_000C);
    busWrite(8'h60, 32'h0000_0009);
    busWrite(8'h30, 32'h0000_00FF);
    busWrite(8'h40, 32'h0000_00FF);
    busWrite(8'h78, 32'hFFFF_FFFF);
    readCheck("R6 idle status", 8'h70, 32'h0);
    check("R9 idle irq", {31'h0, irqOut}, 32'h0);

    pinIn[0] = 1'b1; waitCycles(4);
    readCheck("R6 rising", 8'h70, 32'h1);
    readCheck("R5 sync input", 8'h20, 32'h7);
    check("R9 irq high", {31'h0, irqOut}, 32'h1);
    busWrite(8'h78, 32'h1);
    readCheck("R3 status clear", 8'h70, 32'h0);
    check("R9 irq low", {31'h0, irqOut}, 32'h0);

    pinIn[0] = 1'b0; waitCycles(4);
    readCheck("R6 rising pin ignores fall", 8'h70, 32'h0);

    pinIn[1] = 1'b0; waitCycles(4);
    readCheck("R6 falling", 8'h70, 32'h2);
    busWrite(8'h78, 32'h2);

    pinIn[3] = 1'b1; waitCycles(4);
    readCheck("R7 high level", 8'h70, 32'h8);
    busWrite(8'h78, 32'h8);
    readCheck("R7 clear while level held", 8'h70, 32'h8);
    pinIn[3] = 1'b0; waitCycles(4);
    busWrite(8'h78, 32'h8);
    readCheck("R7 clear after level gone", 8'h70, 32'h0);

    pinIn[2] = 1'b0; waitCycles(4);
    readCheck("R7 low level", 8'h70, 32'h4);
    pinIn[2] = 1'b1; waitCycles(4);
    busWrite(8'h78, 32'h4);
    readCheck("R7 low level released", 8'h70, 32'h0);

    // R8: pin 8 high-level type but not selected
    busWrite(8'h54, 32'h0000_0100);
    busWrite(8'h64, 32'h0000_0100);
    pinIn[8] = 1'b1; waitCycles(4);
    readCheck("R8 unselected pin", 8'h70, 32'h0);

    // R9 masking
    pinIn[0] = 1'b1; waitCycles(4);
    readCheck("R9 status before mask", 8'h70, 32'h1);
    busWrite(8'h40, 32'h0);
    check("R9 masked irq", {31'h0, irqOut}, 32'h0);
    readCheck("R9 status kept", 8'h70, 32'h1);
    busWrite(8'h44, 32'h1);
    check("R9 unmasked irq", {31'h0, irqOut}, 32'h1);
    busWrite(8'h78, 32'h1);
    pinIn[0] = 1'b0; waitCycles(4);

    // R10: clear lands on the edge that detects a rise
    busWrite(8'h74, 32'h1);
    @(negedge clk);
    pinIn[0] = 1'b1;
    @(negedge clk);
    busWrite(8'h78, 32'h1);
    readCheck("R10 hardware set wins", 8'h70, 32'h1);
    busWrite(8'h78, 32'h1);
    readCheck("R10 later clear succeeds", 8'h70, 32'h0);

    // R4: reset mid-run
    busWrite(8'h00, 32'hDEAD_BEEF);
    busWrite(8'h74, 32'h3);
    rstN = 1'b0;
    waitCycles(2);
    check("R4 pinOut after reset", pinOut, 32'h0);
    readCheck("R4 status after reset", 8'h70, 32'h0);
    check("R4 irq after reset", {31'h0, irqOut}, 32'h0);

    finished = 1;
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      finishRun();
    end
  end

endmodule